// File: doc/BRIEF.md
# Ready/Strobe Shift FIFO with Occupancy Bands

This block is a 64-entry first-in first-out buffer. It runs on a single clock, and its data width can be set to 8 or 9 bits. Upstream logic offers a word by raising `shiftIn` for one cycle while `inReady` is high. Downstream logic sees the oldest stored word on `dataOut` as soon as `outReady` is high, with no read request needed. Raising `shiftOut` for one cycle consumes that word, and the next one takes its place.

Two flags report how full the buffer is. `edgeFlag` marks either end of the range: nearly empty or nearly full. `halfFlag` shows whether the buffer holds at least half its depth. An active-low master reset empties the buffer. An output enable parks the data output at high impedance and leaves the stored contents and the flags untouched.

Top module: `hsFifo`

## Requirements
- R1: The buffer holds 64 words, and the `WIDTH` parameter sets the word width to 8 or 9 bits.
- R2: `inReady` is high while fewer than 64 words are stored. A `shiftIn` pulse on a full buffer without a matching `shiftOut` is dropped, and the count and contents do not change.
- R3: `outReady` is high while at least one word is stored. A `shiftOut` pulse on an empty buffer is dropped.
- R4: Words come out in the order they were accepted.
- R5: `edgeFlag` is high when the count is 0..8 or 56..64, and low when the count is 9..55.
- R6: `halfFlag` is high when the count is 32..64 and low when it is 0..31.
- R7: While `rstN` is low the buffer is empty. `inReady` is 1, `outReady` is 0, `halfFlag` is 0 and `edgeFlag` is 1, and any words held before the reset are gone.
- R8: While `outEn` is low, `dataOut` is all Z. In a two-state simulation this shows as all zeros. Contents and flags are unaffected, and the head word comes back when `outEn` returns high.
- R9: Whenever `outReady` is high, the head word is on `dataOut`. In the cycle after a `shiftOut`, `dataOut` shows the next word.
- R10: When `shiftIn` and `shiftOut` are high in the same cycle on a non-empty buffer, both are honoured and the count stays the same. This also holds when the buffer is full: the read frees the slot the write then uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low master reset |
| shiftIn | input | 1 | One-cycle write strobe |
| dataIn | input | WIDTH | Word to store |
| inReady | output | 1 | Space available |
| shiftOut | input | 1 | One-cycle read strobe |
| outReady | output | 1 | A word is available |
| outEn | input | 1 | Output enable; low parks `dataOut` at Z |
| dataOut | output | WIDTH | Head word |
| edgeFlag | output | 1 | Count is at or below 8, or at or above 56 |
| halfFlag | output | 1 | Count is at or above 32 |

## Verification
The first pattern is a single-word fill from empty to full, with the flags checked after every write. It places each band edge at its exact count (8/9, 31/32, 55/56, 63/64). A full drain does the same in the opposite direction and also checks ordering across the pointer wrap.

Several patterns are aimed at specific faults:
- Strobes on a full buffer and on an empty buffer separate a dropped request from one that corrupts memory or the count.
- Simultaneous read and write on a full buffer shows whether the read-frees-slot rule was implemented.
- A long run of mixed strobes with varying data checks order and occupancy while both pointers move at once.
- A reset in the middle of a stream shows that no stale words survive.

// File: rtl/hsFifoPkg.sv
package hsFifoPkg;
  parameter int DEPTH  = 64;
  parameter int ADDR_W = $clog2(DEPTH);
  parameter int CNT_W  = ADDR_W + 1;
  // occupancy band edges
  parameter int LOW_EDGE  = DEPTH / 8;
  parameter int HIGH_EDGE = DEPTH - DEPTH / 8;
  parameter int HALF_MARK = DEPTH / 2;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
  } memCtl_t;
endpackage

// File: rtl/hsFifoCtrl.sv
module hsFifoCtrl
  import hsFifoPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    shiftIn,
  input  logic    shiftOut,
  output memCtl_t memCtl,
  output logic    inReady,
  output logic    outReady,
  output logic    edgeFlag,
  output logic    halfFlag
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              doRead, doWrite;

  assign outReady = (count != '0);
  assign inReady  = (count != FULL_CNT);
  assign doRead   = shiftOut && outReady;
  // a read on a full buffer frees the slot a same-cycle write takes
  assign doWrite  = shiftIn && (inReady || doRead);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWrite) wrPtr <= wrPtr + 1'b1;
      if (doRead)  rdPtr <= rdPtr + 1'b1;
      if (doWrite && !doRead)      count <= count + 1'b1;
      else if (doRead && !doWrite) count <= count - 1'b1;
    end
  end

  assign memCtl.wrEn   = doWrite;
  assign memCtl.wrAddr = wrPtr;
  assign memCtl.rdAddr = rdPtr;

  assign edgeFlag = (count <= CNT_W'(LOW_EDGE)) || (count >= CNT_W'(HIGH_EDGE));
  assign halfFlag = (count >= CNT_W'(HALF_MARK));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && shiftIn && !shiftOut) |=> !inReady && $stable(wrPtr));
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outReady && shiftOut && !shiftIn) |=> !outReady && $stable(rdPtr));
  // R10
  both_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && shiftIn && shiftOut) |=> $stable(count));
  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == $past(count)) || (count == $past(count) + 1'b1) ||
    ($past(count) == count + 1'b1));
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
endmodule

// File: rtl/hsFifoData.sv
module hsFifoData
  import hsFifoPkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  memCtl_t          memCtl,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             outEn,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] headWord;

  always_ff @(posedge clk) begin
    if (memCtl.wrEn) store[memCtl.wrAddr] <= dataIn;
  end

  assign headWord = store[memCtl.rdAddr];
  assign dataOut  = outEn ? headWord : {WIDTH{1'bz}};

  // R1
  initial width_ok_chk: assert (WIDTH == 8 || WIDTH == 9);
endmodule

// File: rtl/hsFifo.sv
module hsFifo
  import hsFifoPkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  input  logic             shiftOut,
  output logic             outReady,
  input  logic             outEn,
  output logic [WIDTH-1:0] dataOut,
  output logic             edgeFlag,
  output logic             halfFlag
);
  memCtl_t memCtl;

  hsFifoCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .memCtl(memCtl), .inReady(inReady), .outReady(outReady),
    .edgeFlag(edgeFlag), .halfFlag(halfFlag)
  );

  hsFifoData #(.WIDTH(WIDTH)) data_i (
    .clk(clk), .memCtl(memCtl), .dataIn(dataIn), .outEn(outEn),
    .dataOut(dataOut)
  );
endmodule

// File: tb/hsFifo_tb.sv
module hsFifo_tb_top;
  localparam int W = 9;
  localparam int D = 64;

  logic clk = 0;
  logic rstN = 0;
  logic shiftIn = 0, shiftOut = 0, outEn = 1;
  logic [W-1:0] dataIn = '0;
  logic inReady, outReady, edgeFlag, halfFlag;
  logic [W-1:0] dataOut;

  int nChecks = 0, nFails = 0, mCount = 0;
  bit done = 0;
  logic [W-1:0] sbq [$];

  always #5 clk = ~clk;

  hsFifo #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .dataIn(dataIn),
    .inReady(inReady), .shiftOut(shiftOut), .outReady(outReady),
    .outEn(outEn), .dataOut(dataOut), .edgeFlag(edgeFlag), .halfFlag(halfFlag)
  );

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkFlags(string tag);
    check(inReady == (mCount < D), {tag, " R2 inReady"}, int'(inReady), int'(mCount < D));
    check(outReady == (mCount > 0), {tag, " R3 outReady"}, int'(outReady), int'(mCount > 0));
    check(edgeFlag == (mCount <= 8 || mCount >= 56), {tag, " R5 edgeFlag"},
          int'(edgeFlag), int'(mCount <= 8 || mCount >= 56));
    check(halfFlag == (mCount >= 32), {tag, " R6 halfFlag"}, int'(halfFlag), int'(mCount >= 32));
  endtask

  // driver: called at posedge+2, returns at next posedge+2
  task automatic step(bit si, bit so, logic [W-1:0] d);
    bit rd, wr;
    rd = so && (mCount > 0);
    wr = si && (mCount < D || rd);
    shiftIn = si; shiftOut = so; dataIn = d;
    if (wr) sbq.push_back(d);
    @(posedge clk); #2;
    shiftIn = 0; shiftOut = 0;
    mCount = mCount + int'(wr) - int'(rd);
  endtask

  // monitor: R4 / R9 ordering and fall-through
  always @(negedge clk) begin
    if (rstN && outEn && shiftOut && outReady) begin
      if (sbq.size() == 0) check(0, "R4 unexpected word", int'(dataOut), -1);
      else begin
        check(dataOut == sbq[0], "R4 order", int'(dataOut), int'(sbq[0]));
        void'(sbq.pop_front());
      end
    end
  end

  initial begin
    #(200_000 * 10);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    @(posedge clk); #2;
    // R7 reset state
    mCount = 0; checkFlags("reset R7");
    rstN = 1;
    @(posedge clk); #2;
    // fill to full, flag bands at every count (R5, R6, R1)
    for (int i = 0; i < D; i++) begin
      step(1, 0, W'(i * 37 + 5));
      checkFlags("fill R1");
      check(outReady && dataOut == W'(5), "R9 head fall-through", int'(dataOut), 5);
    end
    // R2: ignored write when full
    step(1, 0, W'(9'h1AA));
    checkFlags("full write R2");
    // R10: simultaneous on full
    step(1, 1, W'(9'h155));
    checkFlags("full both R10");
    check(!inReady, "R10 inReady stays low", int'(inReady), 0);
    // R8: output enable parks data
    outEn = 0; #1;
    check(dataOut === {W{1'bz}} || dataOut === '0, "R8 parked", int'(dataOut), 0);
    checkFlags("oe off R8");
    @(posedge clk); #2;
    outEn = 1; #1;
    check(dataOut == sbq[0], "R8 restored head", int'(dataOut), int'(sbq[0]));
    // drain
    for (int i = 0; i < D; i++) begin
      step(0, 1, '0);
      checkFlags("drain");
      if (mCount > 0)
        check(dataOut == sbq[0], "R9 next word", int'(dataOut), int'(sbq[0]));
    end
    // R3: ignored read on empty
    step(0, 1, '0);
    checkFlags("empty read R3");
    step(1, 0, W'(9'h0C3));
    check(outReady && dataOut == W'(9'h0C3), "R9 single word", int'(dataOut), 'h0C3);
    step(0, 1, '0);
    // mixed traffic
    lfsr = W'(9'h0B1);
    for (int i = 0; i < 400; i++) begin
      bit si, so;
      lfsr = {lfsr[W-2:0], lfsr[W-1] ^ lfsr[4]};
      si = (i % 3 != 0) || lfsr[0];
      so = (i % 5 < 2) || (lfsr[2] && i > 150);
      step(si, so, lfsr);
      if (i % 25 == 0) checkFlags("mixed R10");
    end
    checkFlags("mixed end");
    // R7 mid-stream reset
    for (int i = 0; i < 10; i++) step(1, 0, W'(i + 1));
    rstN = 0; #1;
    mCount = 0; sbq.delete();
    checkFlags("midreset R7");
    @(posedge clk); #2; rstN = 1;
    step(1, 0, W'(9'h111));
    check(dataOut == W'(9'h111), "R7 no stale word", int'(dataOut), 'h111);
    step(0, 1, '0);
    checkFlags("final");
    check(sbq.size() == 0, "R4 scoreboard empty", sbq.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule